// File: doc/BRIEF.md
# Platform System Control Register Bank

This block is a byte-wide register bank for platform control and identification. A host issues single-cycle byte reads and writes on a flat port address. Writes to control ports set level outputs: a software reset request, a little-endian mode flag, a disk activity indicator, four cache-control bits and the I/O map-type select that the address bridge uses. Writes to two lock ports send one-cycle toggle strobes to a non-volatile memory controller.

Reads of identification ports return fixed bytes. Reads of control ports that keep state return that state. Two scratch bytes hold any value written to them. A read of any other address returns all ones. Read data is registered: it appears in the cycle after the read strobe and holds until the next read. All stored state clears on reset. This leaves the reset request low and selects contiguous map mode.

Top module: `sysctl_bank`

## Requirements
- R1: After reset, every stored bit is zero. So soft_rst_o, le_mode_o, disk_led_o, cache_ctl_o and map_sel_o are 0, rd_data is 0x00, and both scratch bytes read 0x00.
- R2: A write to address 0x0092 sets soft_rst_o from data bit 0 and le_mode_o from data bit 1, starting the cycle after the write. Both hold until the next such write.
- R3: A read of address 0x0092 returns 0x00 whatever was written there.
- R4: Reads return fixed bytes at these addresses: 0x0800 gives 0xEF, 0x0802 gives 0xAD, 0x0803 gives 0xE0, 0x080C gives 0x3C, 0x0810 gives 0x39, 0x0818 gives 0x00 and 0x0823 gives 0x03.
- R5: Writes to 0x0800, 0x0802 and 0x0803 change no output and no read value.
- R6: Data bit 0 of a write to 0x0808 sets or clears disk_led_o, starting the cycle after the write.
- R7: A write to 0x0810 raises lock1_o, and a write to 0x0812 raises lock2_o. Each strobe is high for exactly the one cycle after the write, whatever the data.
- R8: A write to 0x081C stores data bits 3:0 on cache_ctl_o. A read of 0x081C returns them with bits 7:4 zero.
- R9: A write to 0x0850 stores data bit 0 on map_sel_o. A read of 0x0850 returns it in bit 0, with bits 7:1 zero.
- R10: A read of any address not listed in R3, R4, R8, R9 or R11 returns 0xFF. This includes 0x0808, 0x0812 and 0x0814.
- R11: Addresses 0x0398 and 0x0399 are two independent scratch bytes. Each reads back the last byte written to it.
- R12: rd_data changes only in the cycle after a cycle with rd_en high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 16 | Port address of the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read byte |
| soft_rst_o | output | 1 | Software reset request level |
| le_mode_o | output | 1 | Little-endian mode flag |
| disk_led_o | output | 1 | Disk activity indicator |
| cache_ctl_o | output | 4 | Cache-control bits |
| map_sel_o | output | 1 | I/O map-type select (0 selects contiguous) |
| lock1_o | output | 1 | Lock-toggle strobe 1 |
| lock2_o | output | 1 | Lock-toggle strobe 2 |

## Verification
Every result is due exactly one clock after the edge that captures the access. Level outputs and read data change after the capturing edge, and a lock strobe is high only during the following cycle. The bench drives each access on a falling edge and removes it on the next falling edge, then samples at that falling edge, which is one cycle after capture. For strobes it samples again one cycle later to confirm the pulse has ended. To check that a write was ignored, the bench compares every output captured before and after the write, then reads the port back.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned N_FIXED = 8;

  localparam logic [15:0] PORT_CTL   = 16'h0092;
  localparam logic [15:0] PORT_LED   = 16'h0808;
  localparam logic [15:0] PORT_LOCK1 = 16'h0810;
  localparam logic [15:0] PORT_LOCK2 = 16'h0812;
  localparam logic [15:0] PORT_CACHE = 16'h081C;
  localparam logic [15:0] PORT_MAP   = 16'h0850;
  localparam logic [15:0] PORT_ID0   = 16'h0800;
  localparam logic [15:0] PORT_ID1   = 16'h0802;
  localparam logic [15:0] PORT_ID2   = 16'h0803;

  typedef struct packed {
    logic ctl;
    logic led;
    logic lock1;
    logic lock2;
    logic cache;
    logic mapsel;
    logic scratch;
  } wsel_t;

  typedef enum logic [2:0] {
    RD_DEFAULT = 3'd0,
    RD_CONST   = 3'd1,
    RD_CACHE   = 3'd2,
    RD_MAP     = 3'd3,
    RD_SCRATCH = 3'd4
  } rsrc_t;

  // Fixed read-only ports: address of entry k
  function automatic logic [15:0] fixed_addr(int k);
    case (k)
      0:       fixed_addr = 16'h0092;
      1:       fixed_addr = 16'h0800;
      2:       fixed_addr = 16'h0802;
      3:       fixed_addr = 16'h0803;
      4:       fixed_addr = 16'h080C;
      5:       fixed_addr = 16'h0810;
      6:       fixed_addr = 16'h0818;
      default: fixed_addr = 16'h0823;
    endcase
  endfunction

  // Fixed read-only ports: value of entry k
  function automatic logic [BYTE_W-1:0] fixed_val(int k);
    case (k)
      0:       fixed_val = 8'h00;
      1:       fixed_val = 8'hEF;
      2:       fixed_val = 8'hAD;
      3:       fixed_val = 8'hE0;
      4:       fixed_val = 8'h3C;
      5:       fixed_val = 8'h39;
      6:       fixed_val = 8'h00;
      default: fixed_val = 8'h03;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned NUM_SCRATCH  = 2,
  parameter logic [15:0] SCRATCH_BASE = 16'h0398,
  localparam int unsigned IDX_W = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output wsel_t             wsel,
  output rsrc_t             rsrc,
  output logic [BYTE_W-1:0] const_val,
  output logic [IDX_W-1:0]  scr_idx
);

  logic [ADDR_W-1:0] scr_off;
  logic              scr_hit;

  assign scr_off = addr - ADDR_W'(SCRATCH_BASE);
  assign scr_hit = (scr_off < ADDR_W'(NUM_SCRATCH));

  always_comb begin
    wsel      = '0;
    rsrc      = RD_DEFAULT;
    const_val = 8'hFF;
    scr_idx   = '0;

    for (int k = 0; k < N_FIXED; k++) begin
      if (addr == ADDR_W'(fixed_addr(k))) begin
        rsrc      = RD_CONST;
        const_val = fixed_val(k);
      end
    end

    if (addr == ADDR_W'(PORT_CTL))   wsel.ctl   = 1'b1;
    if (addr == ADDR_W'(PORT_LED))   wsel.led   = 1'b1;
    if (addr == ADDR_W'(PORT_LOCK1)) wsel.lock1 = 1'b1;
    if (addr == ADDR_W'(PORT_LOCK2)) wsel.lock2 = 1'b1;

    if (addr == ADDR_W'(PORT_CACHE)) begin
      wsel.cache = 1'b1;
      rsrc       = RD_CACHE;
    end

    if (addr == ADDR_W'(PORT_MAP)) begin
      wsel.mapsel = 1'b1;
      rsrc        = RD_MAP;
    end

    if (scr_hit) begin
      wsel.scratch = 1'b1;
      rsrc         = RD_SCRATCH;
      scr_idx      = scr_off[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned CACHE_W     = 4,
  parameter int unsigned NUM_SCRATCH = 2,
  localparam int unsigned IDX_W = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  wsel_t                         wsel,
  input  logic [BYTE_W-1:0]             wr_data,
  input  logic [IDX_W-1:0]              scr_idx,
  output logic                          soft_rst_o,
  output logic                          le_mode_o,
  output logic                          disk_led_o,
  output logic [CACHE_W-1:0]            cache_ctl_o,
  output logic                          map_sel_o,
  output logic [NUM_SCRATCH*BYTE_W-1:0] scratch_o
);

  logic               ctl_en, led_en, cache_en, map_en;
  logic               soft_rst_d, le_mode_d, disk_led_d, map_sel_d;
  logic [CACHE_W-1:0] cache_d;
  logic               chk_arm;

  assign ctl_en   = wr_en && wsel.ctl;
  assign led_en   = wr_en && wsel.led;
  assign cache_en = wr_en && wsel.cache;
  assign map_en   = wr_en && wsel.mapsel;

  always_comb begin
    soft_rst_d = soft_rst_o;
    le_mode_d  = le_mode_o;
    disk_led_d = disk_led_o;
    cache_d    = cache_ctl_o;
    map_sel_d  = map_sel_o;
    if (ctl_en) begin
      soft_rst_d = wr_data[0];
      le_mode_d  = wr_data[1];
    end
    if (led_en)   disk_led_d = wr_data[0];
    if (cache_en) cache_d    = wr_data[CACHE_W-1:0];
    if (map_en)   map_sel_d  = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      soft_rst_o  <= 1'b0;
      le_mode_o   <= 1'b0;
      disk_led_o  <= 1'b0;
      cache_ctl_o <= '0;
      map_sel_o   <= 1'b0;
    end else begin
      soft_rst_o  <= soft_rst_d;
      le_mode_o   <= le_mode_d;
      disk_led_o  <= disk_led_d;
      cache_ctl_o <= cache_d;
      map_sel_o   <= map_sel_d;
    end
  end

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scratch
    logic              byte_en;
    logic [BYTE_W-1:0] byte_d;

    assign byte_en = wr_en && wsel.scratch && (scr_idx == IDX_W'(g));

    always_comb begin
      byte_d = scratch_o[g*BYTE_W +: BYTE_W];
      if (byte_en) byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scratch_o[g*BYTE_W +: BYTE_W] <= '0;
      else        scratch_o[g*BYTE_W +: BYTE_W] <= byte_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_arm <= 1'b0;
    else        chk_arm <= 1'b1;
  end

  // R2
  soft_rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm && $past(ctl_en) |-> (soft_rst_o == $past(wr_data[0])) && (le_mode_o == $past(wr_data[1])));

  // R6
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm && !$past(led_en) |-> $stable(disk_led_o));

  // R9
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm && !$past(map_en) |-> $stable(map_sel_o));

endmodule

// File: rtl/sysctl_strobe.sv
module sysctl_strobe #(
  parameter int unsigned NUM_LOCK = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_LOCK-1:0] req_i,
  output logic [NUM_LOCK-1:0] pulse_o
);

  logic chk_arm;

  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_lock
    logic pulse_d;

    assign pulse_d = req_i[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_o[g] <= 1'b0;
      else        pulse_o[g] <= pulse_d;
    end

    // R7
    lock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_arm |-> pulse_o[g] == $past(req_i[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_arm <= 1'b0;
    else        chk_arm <= 1'b1;
  end

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
#(
  parameter int unsigned CACHE_W     = 4,
  parameter int unsigned NUM_SCRATCH = 2,
  localparam int unsigned IDX_W = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_en,
  input  rsrc_t                         rsrc,
  input  logic [BYTE_W-1:0]             const_val,
  input  logic [CACHE_W-1:0]            cache_ctl,
  input  logic                          map_sel,
  input  logic [NUM_SCRATCH*BYTE_W-1:0] scratch,
  input  logic [IDX_W-1:0]              scr_idx,
  output logic [BYTE_W-1:0]             rd_data
);

  logic [BYTE_W-1:0] rd_d;
  logic              chk_arm;

  always_comb begin
    case (rsrc)
      RD_CONST:   rd_d = const_val;
      RD_CACHE:   rd_d = BYTE_W'(cache_ctl);
      RD_MAP:     rd_d = BYTE_W'(map_sel);
      RD_SCRATCH: rd_d = scratch[scr_idx*BYTE_W +: BYTE_W];
      default:    rd_d = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_arm <= 1'b0;
    else        chk_arm <= 1'b1;
  end

  // R10
  default_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm && $past(rd_en && rsrc == RD_DEFAULT) |-> rd_data == 8'hFF);

  // R8
  cache_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm && $past(rd_en && rsrc == RD_CACHE) |-> rd_data[7:4] == 4'h0);

  // R12
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_arm && !$past(rd_en) |-> $stable(rd_data));

endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned CACHE_W      = 4,
  parameter int unsigned NUM_SCRATCH  = 2,
  parameter logic [15:0] SCRATCH_BASE = 16'h0398
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  output logic [7:0]         rd_data,
  output logic               soft_rst_o,
  output logic               le_mode_o,
  output logic               disk_led_o,
  output logic [CACHE_W-1:0] cache_ctl_o,
  output logic               map_sel_o,
  output logic               lock1_o,
  output logic               lock2_o
);

  localparam int unsigned IDX_W    = (NUM_SCRATCH > 1) ? $clog2(NUM_SCRATCH) : 1;
  localparam int unsigned NUM_LOCK = 2;

  logic                          rst_meta, rst_sync_n;
  wsel_t                         wsel;
  rsrc_t                         rsrc;
  logic [BYTE_W-1:0]             const_val;
  logic [IDX_W-1:0]              scr_idx;
  logic [NUM_SCRATCH*BYTE_W-1:0] scratch;
  logic [NUM_LOCK-1:0]           lock_req, lock_pulse;
  logic                          id_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  sysctl_decode #(
    .ADDR_W(ADDR_W), .NUM_SCRATCH(NUM_SCRATCH), .SCRATCH_BASE(SCRATCH_BASE)
  ) i_decode (
    .addr(addr), .wsel(wsel), .rsrc(rsrc), .const_val(const_val), .scr_idx(scr_idx)
  );

  sysctl_regs #(
    .CACHE_W(CACHE_W), .NUM_SCRATCH(NUM_SCRATCH)
  ) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wsel(wsel), .wr_data(wr_data),
    .scr_idx(scr_idx), .soft_rst_o(soft_rst_o), .le_mode_o(le_mode_o),
    .disk_led_o(disk_led_o), .cache_ctl_o(cache_ctl_o), .map_sel_o(map_sel_o),
    .scratch_o(scratch)
  );

  assign lock_req = {wr_en && wsel.lock2, wr_en && wsel.lock1};

  sysctl_strobe #(.NUM_LOCK(NUM_LOCK)) i_strobe (
    .clk(clk), .rst_n(rst_sync_n), .req_i(lock_req), .pulse_o(lock_pulse)
  );

  assign lock1_o = lock_pulse[0];
  assign lock2_o = lock_pulse[1];

  sysctl_rdmux #(
    .CACHE_W(CACHE_W), .NUM_SCRATCH(NUM_SCRATCH)
  ) i_rdmux (
    .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .rsrc(rsrc), .const_val(const_val),
    .cache_ctl(cache_ctl_o), .map_sel(map_sel_o), .scratch(scratch),
    .scr_idx(scr_idx), .rd_data(rd_data)
  );

  assign id_port = (addr == ADDR_W'(PORT_ID0)) || (addr == ADDR_W'(PORT_ID1)) ||
                   (addr == ADDR_W'(PORT_ID2));

  // R5
  id_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en && id_port |-> wsel == '0);

  // R11
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_en |-> $onehot0(wsel));

endmodule

// File: tb/test_sysctl_bank.sv
module test_sysctl_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        wr_en, rd_en;
  logic [7:0]  wr_data, rd_data;
  logic        soft_rst_o, le_mode_o, disk_led_o, map_sel_o, lock1_o, lock2_o;
  logic [3:0]  cache_ctl_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sysctl_bank i_sysctl_bank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .soft_rst_o(soft_rst_o), .le_mode_o(le_mode_o),
    .disk_led_o(disk_led_o), .cache_ctl_o(cache_ctl_o), .map_sel_o(map_sel_o),
    .lock1_o(lock1_o), .lock2_o(lock2_o)
  );

  // Vector: {req[3:0], is_read, addr[15:0], data_or_expected[7:0]}
  localparam int NV = 27;
  localparam logic [28:0] VEC [NV] = '{
    {4'd11, 1'b0, 16'h0398, 8'h5A},  // R11
    {4'd11, 1'b0, 16'h0399, 8'hA5},  // R11
    {4'd11, 1'b1, 16'h0398, 8'h5A},  // R11
    {4'd11, 1'b1, 16'h0399, 8'hA5},  // R11
    {4'd11, 1'b0, 16'h0399, 8'h3C},  // R11
    {4'd11, 1'b1, 16'h0398, 8'h5A},  // R11
    {4'd4,  1'b1, 16'h0800, 8'hEF},  // R4
    {4'd4,  1'b1, 16'h0802, 8'hAD},  // R4
    {4'd4,  1'b1, 16'h0803, 8'hE0},  // R4
    {4'd4,  1'b1, 16'h080C, 8'h3C},  // R4
    {4'd4,  1'b1, 16'h0810, 8'h39},  // R4
    {4'd4,  1'b1, 16'h0818, 8'h00},  // R4
    {4'd4,  1'b1, 16'h0823, 8'h03},  // R4
    {4'd3,  1'b0, 16'h0092, 8'hFE},  // R3
    {4'd3,  1'b1, 16'h0092, 8'h00},  // R3
    {4'd8,  1'b0, 16'h081C, 8'hFF},  // R8
    {4'd8,  1'b1, 16'h081C, 8'h0F},  // R8
    {4'd9,  1'b0, 16'h0850, 8'hFF},  // R9
    {4'd9,  1'b1, 16'h0850, 8'h01},  // R9
    {4'd10, 1'b1, 16'h0808, 8'hFF},  // R10
    {4'd10, 1'b1, 16'h0812, 8'hFF},  // R10
    {4'd10, 1'b1, 16'h0814, 8'hFF},  // R10
    {4'd10, 1'b1, 16'h0000, 8'hFF},  // R10
    {4'd10, 1'b1, 16'h0851, 8'hFF},  // R10
    {4'd10, 1'b1, 16'h039A, 8'hFF},  // R10
    {4'd5,  1'b0, 16'h0800, 8'h12},  // R5
    {4'd5,  1'b1, 16'h0800, 8'hEF}   // R5
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [15:0] a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {soft_rst_o, le_mode_o, disk_led_o, map_sel_o, cache_ctl_o};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual 0x00 expected 0x01");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] snap;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 outputs", outs(), 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 locks", {6'b0, lock1_o, lock2_o}, 8'h00);
    do_read(16'h0398); chk("R1 scratch0", rd_data, 8'h00);
    do_read(16'h0399); chk("R1 scratch1", rd_data, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][24]) begin
        do_read(VEC[i][23:8]);
        chk($sformatf("R%0d vector %0d", VEC[i][28:25], i), rd_data, VEC[i][7:0]);
      end else begin
        do_write(VEC[i][23:8], VEC[i][7:0]);
      end
    end

    // R8 / R9 level outputs from the table writes
    chk("R8 cache_ctl_o", {4'h0, cache_ctl_o}, 8'h0F);
    chk("R9 map_sel_o", {7'h0, map_sel_o}, 8'h01);
    do_write(16'h081C, 8'hA5);
    chk("R8 cache low bits", {4'h0, cache_ctl_o}, 8'h05);
    do_write(16'h0850, 8'h02);
    chk("R9 map bit0 only", {7'h0, map_sel_o}, 8'h00);

    // R2 control port (table wrote 0xFE: reset low, LE high)
    chk("R2 after 0xFE", {6'h0, soft_rst_o, le_mode_o}, 8'h01);
    do_write(16'h0092, 8'h01);
    chk("R2 after 0x01", {6'h0, soft_rst_o, le_mode_o}, 8'h02);
    @(negedge clk);
    chk("R2 level held", {6'h0, soft_rst_o, le_mode_o}, 8'h02);
    do_write(16'h0092, 8'h00);
    chk("R2 cleared", {6'h0, soft_rst_o, le_mode_o}, 8'h00);

    // R6 disk indicator
    do_write(16'h0808, 8'hFE);
    chk("R6 bit0 low", {7'h0, disk_led_o}, 8'h00);
    do_write(16'h0808, 8'h01);
    chk("R6 set", {7'h0, disk_led_o}, 8'h01);
    do_read(16'h0808);
    chk("R6 read unmapped", rd_data, 8'hFF);
    chk("R6 held", {7'h0, disk_led_o}, 8'h01);

    // R7 lock strobes
    do_write(16'h0810, 8'h00);
    chk("R7 lock1 pulse", {6'h0, lock1_o, lock2_o}, 8'h02);
    @(negedge clk);
    chk("R7 lock1 ended", {6'h0, lock1_o, lock2_o}, 8'h00);
    do_write(16'h0812, 8'hFF);
    chk("R7 lock2 pulse", {6'h0, lock1_o, lock2_o}, 8'h01);
    @(negedge clk);
    chk("R7 lock2 ended", {6'h0, lock1_o, lock2_o}, 8'h00);

    // R5 identification writes ignored
    snap = outs();
    do_write(16'h0803, 8'hFF);
    chk("R5 no lock", {6'h0, lock1_o, lock2_o}, 8'h00);
    do_write(16'h0802, 8'h00);
    chk("R5 outputs unchanged", outs(), snap);
    do_read(16'h0803);
    chk("R5 id kept", rd_data, 8'hE0);

    // R12 read data holds between reads
    do_read(16'h0802);
    repeat (3) @(negedge clk);
    chk("R12 hold idle", rd_data, 8'hAD);
    do_write(16'h0398, 8'h77);
    chk("R12 hold on write", rd_data, 8'hAD);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 async clear", outs(), 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(16'h0398);
    chk("R1 scratch cleared", rd_data, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule